// File: doc/BRIEF.md
# Pulse-Coded Isolation Link

This block moves one logic level across a modelled isolation barrier. The level is never sent as a steady signal. Only discrete events cross the barrier: a one-cycle "set" pulse or a one-cycle "reset" pulse. The transmit half watches its input. It emits a set pulse on each rising edge and a reset pulse on each falling edge. When the input has been quiet for a programmable number of bit-time ticks, it re-sends the present level as a refresh pulse. The receive half holds the level in a bistable latch that the pulses drive.

A watchdog in the receive half counts bit-time ticks since the last pulse arrived. If it reaches its limit, the receiver decides that the far side is dead. It then forces its output to a configurable default level and drops a link-valid flag. The first pulse that arrives afterwards restores normal tracking.

The bench uses a blocking input to model a barrier that loses pulses. While the input is high, the pulses do not reach the receiver. The transmitter still shows its pulses on two observation outputs.

Top module: `isolink_top`

## Requirements
- R1: A rising input edge produces a set pulse and a falling edge produces a reset pulse. Each pulse is exactly one clock wide and appears on the clock after the edge is sampled. Set and reset are never high together.
- R2: The receiver output goes high one clock after a set pulse crosses the barrier and low one clock after a reset pulse crosses. With no pulse and no watchdog expiry, the output holds its value. If both pulses arrive together, reset wins.
- R3: After REFRESH_TICKS (default 12) bit-time ticks with no input edge, the transmitter sends a refresh pulse that matches the input: set when the input is high, reset when it is low.
- R4: Every edge and every refresh pulse clears the idle count. Refresh pulses therefore repeat every REFRESH_TICKS ticks for as long as the input stays steady.
- R5: An edge pulse lost at the barrier leaves the output wrong only until the next refresh. The refresh comes on the REFRESH_TICKS-th tick after the edge, and the output is corrected at that point.
- R6: If WD_TICKS (default 36, which must exceed REFRESH_TICKS) ticks pass with no received pulse, then on the WD_TICKS-th tick the output is forced to DEFAULT_LEVEL (default 0) and linkValid goes low. After only WD_TICKS-1 such ticks, the output and linkValid are unchanged.
- R7: The first pulse received after a timeout sets the output to the level that pulse carries and raises linkValid again.
- R8: Asynchronous reset (rstN low) sets the output to DEFAULT_LEVEL, sets linkValid low and clears both counters. The transmitter treats the previous input as DEFAULT_LEVEL. An input that differs from DEFAULT_LEVEL when reset is released therefore produces an edge pulse on the first clock after release.
- R9: While barrierBlock is high, no pulse reaches the receiver. The transmitter still emits its pulses on setPulse and resetPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe marking each bit time |
| dataIn | input | 1 | Level to carry across the barrier |
| barrierBlock | input | 1 | High drops any pulse crossing the barrier this cycle |
| dataOut | output | 1 | Receiver latch output |
| linkValid | output | 1 | Low while the watchdog forces the default level |
| setPulse | output | 1 | Transmit-side set pulse, before the barrier |
| resetPulse | output | 1 | Transmit-side reset pulse, before the barrier |

## Verification
The assertions check the cycle-level pulse rules on every cycle:
- Pulses are one cycle wide and never overlap.
- A set pulse only ever carries a high input.
- The latch follows each pulse on the next clock and holds otherwise.
- linkValid falls only on a tick, and only with the output at the default.
- linkValid is restored by any pulse.

Only the bench scenarios can show the counted windows:
- a refresh on exactly the twelfth quiet tick;
- recovery from a dropped edge;
- the watchdog holding at 35 silent ticks and firing on the 36th;
- restart behaviour after reset.

// File: rtl/isolink_pkg.sv
package isolink_pkg;
  typedef struct packed {
    logic setP;
    logic rstP;
  } pulse_t;
endpackage

// File: rtl/isolink_tx.sv
module isolink_tx
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_TICKS = 12,
  parameter bit          DEFAULT_LEVEL = 1'b0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitTick,
  input  logic   dataIn,
  output pulse_t strobe
);
  localparam int unsigned RW = $clog2(REFRESH_TICKS + 1);
  localparam logic [RW-1:0] REFRESH_LAST = RW'(REFRESH_TICKS - 1);

  logic          prevIn;
  logic [RW-1:0] idleCnt;
  logic          riseEdge;
  logic          fallEdge;
  logic          anyEdge;
  logic          refreshDue;

  always_comb begin
    riseEdge   = dataIn & ~prevIn;
    fallEdge   = ~dataIn & prevIn;
    anyEdge    = riseEdge | fallEdge;
    refreshDue = bitTick && !anyEdge && (idleCnt == REFRESH_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn      <= DEFAULT_LEVEL;
      idleCnt     <= '0;
      strobe.setP <= 1'b0;
      strobe.rstP <= 1'b0;
    end else begin
      prevIn      <= dataIn;
      strobe.setP <= riseEdge | (refreshDue & dataIn);
      strobe.rstP <= fallEdge | (refreshDue & ~dataIn);
      if (anyEdge || refreshDue) begin
        idleCnt <= '0;
      end else if (bitTick) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  AST_SET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setP |=> !strobe.setP); // R1
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstP |=> !strobe.rstP); // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setP && strobe.rstP)); // R1
  AST_SET_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setP |-> $past(dataIn)); // R3
  AST_RST_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstP |-> !$past(dataIn)); // R3
endmodule

// File: rtl/isolink_rx.sv
module isolink_rx
  import isolink_pkg::*;
#(
  parameter int unsigned WD_TICKS      = 36,
  parameter bit          DEFAULT_LEVEL = 1'b0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitTick,
  input  pulse_t strobe,
  output logic   level,
  output logic   linkValid
);
  localparam int unsigned WW = $clog2(WD_TICKS + 1);
  localparam logic [WW-1:0] WD_LAST = WW'(WD_TICKS - 1);

  logic [WW-1:0] wdCnt;
  logic          anyPulse;
  logic          wdExpire;

  always_comb begin
    anyPulse = strobe.setP | strobe.rstP;
    wdExpire = bitTick && !anyPulse && (wdCnt == WD_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level     <= DEFAULT_LEVEL;
      linkValid <= 1'b0;
      wdCnt     <= '0;
    end else begin
      if (strobe.rstP) begin
        level <= 1'b0;
      end else if (strobe.setP) begin
        level <= 1'b1;
      end else if (wdExpire) begin
        level <= DEFAULT_LEVEL;
      end

      if (anyPulse) begin
        linkValid <= 1'b1;
      end else if (wdExpire) begin
        linkValid <= 1'b0;
      end

      if (anyPulse) begin
        wdCnt <= '0;
      end else if (bitTick && (wdCnt != WD_LAST)) begin
        wdCnt <= wdCnt + 1'b1;
      end
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstP |=> !level); // R2
  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setP && !strobe.rstP) |=> level); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!anyPulse && !bitTick) |=> $stable(level)); // R2
  AST_WD_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkValid) |-> (level == DEFAULT_LEVEL)); // R6
  AST_WD_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkValid) |-> $past(bitTick)); // R6
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |=> linkValid); // R7
endmodule

// File: rtl/isolink_top.sv
module isolink_top
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_TICKS = 12,
  parameter int unsigned WD_TICKS      = 36,
  parameter bit          DEFAULT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic dataIn,
  input  logic barrierBlock,
  output logic dataOut,
  output logic linkValid,
  output logic setPulse,
  output logic resetPulse
);
  pulse_t txStrobe;
  pulse_t rxStrobe;

  initial begin
    AST_WD_ABOVE_REFRESH: assert (WD_TICKS > REFRESH_TICKS); // R6
  end

  isolink_tx #(
    .REFRESH_TICKS(REFRESH_TICKS),
    .DEFAULT_LEVEL(DEFAULT_LEVEL)
  ) uTx (
    .clk     (clk),
    .rstN    (rstN),
    .bitTick (bitTick),
    .dataIn  (dataIn),
    .strobe  (txStrobe)
  );

  always_comb begin
    rxStrobe.setP = txStrobe.setP & ~barrierBlock;
    rxStrobe.rstP = txStrobe.rstP & ~barrierBlock;
    setPulse      = txStrobe.setP;
    resetPulse    = txStrobe.rstP;
  end

  isolink_rx #(
    .WD_TICKS     (WD_TICKS),
    .DEFAULT_LEVEL(DEFAULT_LEVEL)
  ) uRx (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .strobe    (rxStrobe),
    .level     (dataOut),
    .linkValid (linkValid)
  );

  AST_BLOCK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (barrierBlock && !linkValid) |=> !linkValid); // R9
endmodule

// File: tb/tb_isolink_top.sv
`timescale 1ns/1ps
module tb_isolink_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic dataIn = 1'b0;
  logic barrierBlock = 1'b0;
  logic dataOut, linkValid, setPulse, resetPulse;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  isolink_top dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .dataIn(dataIn),
    .barrierBlock(barrierBlock), .dataOut(dataOut), .linkValid(linkValid),
    .setPulse(setPulse), .resetPulse(resetPulse)
  );

  typedef struct packed {
    logic       din;
    logic       blk;
    logic [7:0] ticks;
    logic       expOut;
    logic       expValid;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd1,  1'b1, 1'b1},  // R1 R2 rising edge sets output
    '{1'b0, 1'b0, 8'd1,  1'b0, 1'b1},  // R1 R2 falling edge clears output
    '{1'b1, 1'b0, 8'd20, 1'b1, 1'b1},  // R3 refresh keeps high
    '{1'b1, 1'b1, 8'd40, 1'b0, 1'b0},  // R6 silence forces default
    '{1'b1, 1'b0, 8'd12, 1'b1, 1'b1},  // R7 refresh restores
    '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1},  // R9 dropped edge, output stale
    '{1'b0, 1'b0, 8'd10, 1'b1, 1'b1},  // R5 still stale at 11 ticks
    '{1'b0, 1'b0, 8'd1,  1'b0, 1'b1},  // R5 repaired on 12th tick
    '{1'b0, 1'b0, 8'd30, 1'b0, 1'b1},  // R4 repeated low refresh
    '{1'b0, 1'b1, 8'd29, 1'b0, 1'b1},  // R6 35 silent ticks, still valid
    '{1'b0, 1'b1, 8'd1,  1'b0, 1'b0},  // R6 36th tick times out
    '{1'b1, 1'b0, 8'd1,  1'b1, 1'b1}   // R7 edge restores tracking
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset output", dataOut, 1'b0);
    check("R8 reset valid", linkValid, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 no pulse at equal input", setPulse | resetPulse, 1'b0);
    check("R8 valid low after release", linkValid, 1'b0);

    for (int v = 0; v < NV; v++) begin
      dataIn = VECS[v].din;
      barrierBlock = VECS[v].blk;
      runTicks(int'(VECS[v].ticks));
      repeat (2) @(negedge clk);
      check($sformatf("R2 vector %0d output", v), dataOut, VECS[v].expOut);
      check($sformatf("R6 vector %0d valid", v), linkValid, VECS[v].expValid);
    end
    barrierBlock = 1'b0;

    // R1 pulse width on falling then rising edge
    @(negedge clk);
    dataIn = 1'b0;
    @(negedge clk);
    check("R1 reset pulse present", resetPulse, 1'b1);
    check("R1 no set on fall", setPulse, 1'b0);
    @(negedge clk);
    check("R1 reset pulse one cycle", resetPulse, 1'b0);
    dataIn = 1'b1;
    @(negedge clk);
    check("R1 set pulse present", setPulse, 1'b1);
    check("R1 no reset on rise", resetPulse, 1'b0);
    @(negedge clk);
    check("R1 set pulse one cycle", setPulse, 1'b0);
    check("R2 output follows set", dataOut, 1'b1);

    // R8 reset mid-run with input high
    rstN = 1'b0;
    #1;
    check("R8 async reset output", dataOut, 1'b0);
    check("R8 async reset valid", linkValid, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 edge pulse after release", setPulse, 1'b1);
    @(negedge clk);
    check("R8 output after release", dataOut, 1'b1);
    check("R7 valid after release pulse", linkValid, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule